// File: doc/BRIEF.md
# Next-PC and Branch Unit

This unit owns the program counter of a word-addressed 32-bit processor. Each time the pipeline asks it to step, it works out the address of the following instruction from the current PC, the value already read for the first source register and the 16-bit immediate. It does this for six kinds of control flow: straight-line, branch when the register is zero, branch when the register is nonzero, register jump, register jump with link, and halt. For the linking jump it also raises a write request towards general register 31. That request carries the address of the instruction after the jump.

Every address counts whole words, so straight-line flow adds one. A taken branch lands one word past the branch plus the sign-extended offset, and all sums wrap modulo 2^32. A halt freezes the PC and latches a halted flag. After that the step input has no effect until a synchronous reset. Fetch, decode and the register file lie outside this block. The link request is meant for the register file's write port.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_q` becomes 0 and `halted` becomes 0 at that edge.
- R2: `ctrl` encoding: 0 straight-line, 1 branch-if-zero, 2 branch-if-nonzero, 3 register jump, 4 register jump with link, 5 halt. Codes 0, 6 and 7 each advance the PC by one, modulo 2^32 (0xFFFFFFFF steps to 0).
- R3: With code 1, the PC becomes PC+1+sext(imm) when `rs1_val` is all zeros, and PC+1 otherwise.
- R4: With code 2, the PC becomes PC+1+sext(imm) when `rs1_val` is nonzero, and PC+1 otherwise.
- R5: With code 3, the PC becomes `rs1_val`.
- R6: With code 4, in the same cycle `link_we` is 1, `link_addr` is 31 and `link_data` is the pre-update PC+1, and at the edge the PC becomes `rs1_val`. The value is the one presented, even if it came from register 31.
- R7: With code 5, `halted` becomes 1 and the PC keeps its value. While halted, the PC does not change and `link_we` stays 0 whatever `step` and `ctrl` are, until reset.
- R8: While `step` is 0, the PC holds and `link_we` is 0.
- R9: `pc_next` shows the value `pc_q` takes at the next rising edge when reset is low. It equals `pc_q` when no step is taken.
- R10: Target sums wrap modulo 2^32. A branch-if-zero from PC 0 with imm = -5 lands on 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Execute the presented instruction this cycle |
| ctrl | input | 3 | Control-flow class (encoding in R2) |
| rs1_val | input | 32 | Value read for the first source register |
| imm | input | 16 | Immediate field, two's complement |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | PC value after the coming edge |
| link_we | output | 1 | Link write request |
| link_addr | output | 5 | Link destination register index (31) |
| link_data | output | 32 | Link value, current PC + 1 |
| halted | output | 1 | Halt has executed |

## Verification
The linking jump makes two things happen in one cycle. The unit emits the return address and it redirects the PC to the register value, which may come from the very register being written. The bench presents a linking jump whose `rs1_val` differs from PC+1. It checks `link_data` against the old PC+1 before the edge and `pc_q` against the presented value after the edge. Halt and a step request also meet in one cycle. The bench keeps `step` high with a linking jump on the inputs after the halt. It then judges whether the PC stayed frozen and whether `link_we` stayed low.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    CF_SEQ  = 3'd0,
    CF_BEQZ = 3'd1,
    CF_BNEZ = 3'd2,
    CF_JR   = 3'd3,
    CF_JALR = 3'd4,
    CF_HALT = 3'd5
  } ctrl_e;

endpackage

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  br_pc,
  output logic             rs1_zero
);

  logic [XLEN-1:0] offset;

  // Wrapping add: the sum is truncated to XLEN bits.
  function automatic logic [XLEN-1:0] add_wrap(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  generate
    if (IMM_W < XLEN) begin : g_extend
      assign offset = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign offset = imm[XLEN-1:0];
    end
  endgenerate

  assign seq_pc   = add_wrap(pc, {{(XLEN-1){1'b0}}, 1'b1});
  assign br_pc    = add_wrap(seq_pc, offset);
  assign rs1_zero = (rs1_val == '0);

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ctrl_e           ctrl,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] br_pc,
  input  logic [XLEN-1:0] rs1_val,
  input  logic            rs1_zero,
  output logic [XLEN-1:0] target,
  output logic            taken,
  output logic            is_link,
  output logic            is_stop
);

  always_comb begin
    target  = seq_pc;
    taken   = 1'b0;
    is_link = 1'b0;
    is_stop = 1'b0;
    case (ctrl)
      CF_BEQZ: begin
        taken = rs1_zero;
        if (rs1_zero) target = br_pc;
      end
      CF_BNEZ: begin
        taken = !rs1_zero;
        if (!rs1_zero) target = br_pc;
      end
      CF_JR:   target = rs1_val;
      CF_JALR: begin
        target  = rs1_val;
        is_link = 1'b1;
      end
      CF_HALT: begin
        target  = pc;
        is_stop = 1'b1;
      end
      default: target = seq_pc;
    endcase
  end

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int NUM_REGS = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        step,
  input  logic [2:0]                  ctrl,
  input  logic [XLEN-1:0]             rs1_val,
  input  logic [IMM_W-1:0]            imm,
  output logic [XLEN-1:0]             pc_q,
  output logic [XLEN-1:0]             pc_next,
  output logic                        link_we,
  output logic [$clog2(NUM_REGS)-1:0] link_addr,
  output logic [XLEN-1:0]             link_data,
  output logic                        halted
);

  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int LINK_IDX = NUM_REGS - 1;

  logic [XLEN-1:0] seq_pc, br_pc, target;
  logic            rs1_zero, taken, is_link, is_stop;
  logic            advance;

  npc_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_target (
    .pc      (pc_q),
    .rs1_val (rs1_val),
    .imm     (imm),
    .seq_pc  (seq_pc),
    .br_pc   (br_pc),
    .rs1_zero(rs1_zero)
  );

  npc_select #(.XLEN(XLEN)) u_select (
    .ctrl    (ctrl_e'(ctrl)),
    .pc      (pc_q),
    .seq_pc  (seq_pc),
    .br_pc   (br_pc),
    .rs1_val (rs1_val),
    .rs1_zero(rs1_zero),
    .target  (target),
    .taken   (taken),
    .is_link (is_link),
    .is_stop (is_stop)
  );

  assign advance   = step && !halted;
  assign pc_next   = advance ? target : pc_q;
  assign link_we   = advance && is_link;
  assign link_addr = REG_AW'(LINK_IDX);
  assign link_data = seq_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      halted <= 1'b0;
    end else if (advance) begin
      pc_q <= target;
      if (is_stop) halted <= 1'b1;
    end
  end

  // R9
  pc_follows_next_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pc_q == $past(pc_next));

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && step && !halted && (ctrl == 3'd0)) |=> pc_q == $past(pc_q) + 1);

  // R3
  branch_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && advance && taken) |=> pc_q == $past(br_pc));

  // R6
  link_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && link_we) |=> (pc_q == $past(rs1_val)) && !halted);

  // R7
  halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && step && !halted && (ctrl == 3'd5)) |=> halted && $stable(pc_q));

  // R7
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && halted) |=> halted && $stable(pc_q));

  // R7
  halt_no_link_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !link_we);

endmodule

// File: tb/next_pc_unit_test.sv
module next_pc_unit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst, step;
  logic [2:0]  ctrl;
  logic [31:0] rs1_val;
  logic [15:0] imm;
  logic [31:0] pc_q, pc_next, link_data;
  logic        link_we, halted;
  logic [4:0]  link_addr;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_pc;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  next_pc_unit uut (
    .clk(clk), .rst(rst), .step(step), .ctrl(ctrl), .rs1_val(rs1_val), .imm(imm),
    .pc_q(pc_q), .pc_next(pc_next), .link_we(link_we), .link_addr(link_addr),
    .link_data(link_data), .halted(halted)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model of the destination address.
  function automatic logic [31:0] model(input logic [2:0] c, input logic [31:0] pc,
                                        input logic [31:0] r, input logic [15:0] i);
    logic [31:0] nxt = pc + 32'd1;
    logic signed [31:0] off = $signed(i);
    case (c)
      3'd1: return (r == 0) ? nxt + off : nxt;
      3'd2: return (r != 0) ? nxt + off : nxt;
      3'd3, 3'd4: return r;
      3'd5: return pc;
      default: return nxt;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; step = 0; ctrl = 0; rs1_val = 0; imm = 0;
    @(posedge clk); #1;
    rst = 0;
    exp_pc = 0;
    chk("R1 pc", pc_q, 32'd0);
    chk("R1 halted", {31'd0, halted}, 32'd0);
  endtask

  task automatic do_op(input string req, input logic [2:0] c,
                       input logic [31:0] r, input logic [15:0] i);
    logic [31:0] e;
    @(negedge clk);
    step = 1; ctrl = c; rs1_val = r; imm = i;
    #1;
    e = model(c, exp_pc, r, i);
    chk({req, " pc_next R9"}, pc_next, e);
    chk({req, " link_we"}, {31'd0, link_we}, {31'd0, (c == 3'd4)});
    if (c == 3'd4) begin
      chk("R6 link_addr", {27'd0, link_addr}, 32'd31);
      chk("R6 link_data", link_data, exp_pc + 32'd1);
    end
    @(posedge clk); #1;
    step = 0;
    exp_pc = e;
    chk({req, " pc"}, pc_q, e);
  endtask

  task automatic t_sequential();
    do_op("R2 seq", 3'd0, 32'h1234, 16'h0);
    do_op("R2 seq", 3'd0, 32'h0, 16'hFFFF);
    do_op("R2 code6", 3'd6, 32'h0, 16'h0);
    do_op("R2 code7", 3'd7, 32'h5, 16'h10);
    do_op("R5 jr", 3'd3, 32'hFFFF_FFFF, 16'h0);
    do_op("R2 wrap", 3'd0, 32'h0, 16'h0);
    chk("R2 wrap to zero", pc_q, 32'd0);
  endtask

  task automatic t_branches();
    do_op("R3 beqz taken", 3'd1, 32'h0, 16'h0010);
    do_op("R3 beqz not", 3'd1, 32'h8000_0000, 16'h0010);
    do_op("R4 bnez taken", 3'd2, 32'h1, 16'hFFF0);
    do_op("R4 bnez not", 3'd2, 32'h0, 16'h0100);
    do_op("R3 beqz back", 3'd1, 32'h0, 16'h8000);
  endtask

  task automatic t_wrap();
    do_reset();
    do_op("R10 neg wrap", 3'd1, 32'h0, 16'hFFFB);
    chk("R10 dest", pc_q, 32'hFFFF_FFFC);
  endtask

  task automatic t_jumps();
    do_op("R5 jr", 3'd3, 32'h0000_4000, 16'h7);
    do_op("R6 jalr", 3'd4, 32'hDEAD_0000, 16'h0);
    do_op("R6 jalr from r31", 3'd4, 32'h0000_4001, 16'h0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    step = 0; ctrl = 3'd4; rs1_val = 32'h99; imm = 16'h3;
    #1;
    chk("R8 no link", {31'd0, link_we}, 32'd0);
    chk("R8 R9 pc_next hold", pc_next, exp_pc);
    @(posedge clk); #1;
    chk("R8 pc hold", pc_q, exp_pc);
  endtask

  task automatic t_halt();
    do_op("R7 halt", 3'd5, 32'h0, 16'h0);
    chk("R7 halted set", {31'd0, halted}, 32'd1);
    @(negedge clk);
    step = 1; ctrl = 3'd4; rs1_val = 32'h77; imm = 0;
    #1;
    chk("R7 no link while halted", {31'd0, link_we}, 32'd0);
    repeat (3) @(posedge clk);
    #1;
    chk("R7 pc frozen", pc_q, exp_pc);
    ctrl = 3'd0;
    @(posedge clk); #1;
    chk("R7 pc frozen seq", pc_q, exp_pc);
    step = 0;
    do_reset();
    do_op("R1 after reset", 3'd0, 32'h0, 16'h0);
  endtask

  initial begin
    rst = 1; step = 0; ctrl = 0; rs1_val = 0; imm = 0; exp_pc = 0;
    do_reset();
    t_sequential();
    t_branches();
    t_jumps();
    t_idle();
    t_wrap();
    t_halt();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

endmodule